// File: doc/BRIEF.md
# SIMT Warp Divergence Stack

This block tracks the active-thread mask and the path-start program counter for one warp of threads that execute in lockstep. When a branch resolves, it receives one taken bit per thread. Only threads that are currently active take part in the decision. If all of them agree, the warp keeps going with the same mask. The new path PC is the branch target when every active thread takes the branch, and the fall-through PC when none does.

If the active threads disagree, the warp splits. The block first pushes a rejoin record onto a small hardware stack. This record holds the join PC and the full mask from before the branch. It then pushes a deferred record holding the branch target and the mask of the taken threads. The warp goes on down the fall-through path with only the not-taken threads enabled. Each time a path ends at the join point, the fetch side pulses a path-end signal. The block then pops the top record and resumes from its PC and mask: first the deferred taken path, then the rejoined full warp.

The stack has a fixed depth. If a split does not have room for both records, nothing is pushed, the warp state is left as it was, and a sticky overflow flag is set.

Top module: `simt_div_stack`

## Requirements
- R1: After reset, `path_pc` equals the parameter `RESET_PC` (default 0x100), `act_mask` is all ones, `stack_ovf` is 0 and the stack is empty.
- R2: On a branch whose taken vector, masked by the active threads, equals the active mask, `path_pc` becomes `br_target` on the next cycle, `act_mask` is unchanged and nothing is pushed.
- R3: On a branch whose masked taken vector is zero, `path_pc` becomes `br_fallthru` on the next cycle, `act_mask` is unchanged and nothing is pushed.
- R4: On a branch whose masked taken vector is neither zero nor the active mask, `path_pc` becomes `br_fallthru` and `act_mask` becomes the active threads that did not take the branch. The stack receives a rejoin record (`br_join_pc`, pre-branch mask) and then, on top of it, a deferred record (`br_target`, masked taken vector).
- R5: Taken bits of inactive threads have no effect. A branch never sets a bit in `act_mask` that was clear before it.
- R6: A `path_end` pulse with a non-empty stack loads `path_pc` and `act_mask` from the top record and removes that record. After a split, the pops therefore restore the taken path first and the rejoined full mask second.
- R7: A `path_end` pulse with an empty stack is ignored: `path_pc` is unchanged and `act_mask` stays all ones.
- R8: The stack holds `DEPTH` records (default 8). A split that finds fewer than two free records sets `stack_ovf`, pushes nothing, and leaves `path_pc` and `act_mask` unchanged.
- R9: Once set, `stack_ovf` stays 1 until reset.
- R10: When `br_valid` and `path_end` are high in the same cycle, the branch is processed and the path-end pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch has resolved this cycle |
| br_taken | input | LANES | Per-thread taken vector |
| br_target | input | PCW | Branch target PC |
| br_fallthru | input | PCW | Not-taken (fall-through) PC |
| br_join_pc | input | PCW | Reconvergence PC for this branch |
| path_end | input | 1 | Current path has reached its join point |
| path_pc | output | PCW | Start PC of the path now executing |
| act_mask | output | LANES | Active-thread mask |
| stack_ovf | output | 1 | Sticky stack overflow flag |

## Verification
Branches are driven with uniform-taken, uniform-not-taken and split taken vectors. This separates the two no-push outcomes from a real divergence. A second branch is nested inside a diverged subset with taken bits set on inactive threads, so a design that does not gate by the active mask pushes records or reports a split where it should not. The records are then popped one by one and the stack is popped past empty, which checks the push order and the empty-pop behaviour. A chain of five splits fills the eight-record stack and overflows it; the eight pops that follow show that the overflowing split left no record behind and that the flag stays set. A branch coinciding with a path-end pulse checks which of the two wins.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

  // Outcome of one resolved branch against the current active mask
  typedef enum logic [1:0] {
    BK_NONE     = 2'd0,
    BK_TAKEN    = 2'd1,
    BK_NOTTAKEN = 2'd2,
    BK_SPLIT    = 2'd3
  } br_kind_e;

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
  import simt_div_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             valid,
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] taken_act,
  output logic [LANES-1:0] nt_act,
  output br_kind_e         kind
);

  // Only threads that are enabled take part in the branch decision
  assign taken_act = taken & active;
  assign nt_act    = active & ~taken;

  always_comb begin
    if (!valid)
      kind = BK_NONE;
    else if (taken_act == '0)
      kind = BK_NOTTAKEN;
    else if (taken_act == active)
      kind = BK_TAKEN;
    else
      kind = BK_SPLIT;
  end

endmodule

// File: rtl/simt_recon_lifo.sv
module simt_recon_lifo #(
  parameter int LANES = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_two,
  input  logic [PCW-1:0]   lo_pc,
  input  logic [LANES-1:0] lo_mask,
  input  logic [PCW-1:0]   hi_pc,
  input  logic [LANES-1:0] hi_mask,
  input  logic             pop,
  output logic [PCW-1:0]   top_pc,
  output logic [LANES-1:0] top_mask,
  output logic             empty,
  output logic             room_two
);

  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SPW = $clog2(DEPTH + 1);

  logic [PCW-1:0]   pc_mem   [DEPTH];
  logic [LANES-1:0] mask_mem [DEPTH];
  logic [SPW-1:0]   sp;
  logic [IW-1:0]    wr_lo, wr_hi, rd_top;

  assign wr_lo    = IW'(sp);
  assign wr_hi    = wr_lo + IW'(1);
  assign rd_top   = wr_lo - IW'(1);
  assign empty    = (sp == '0);
  assign room_two = (32'(sp) + 2) <= DEPTH;
  assign top_pc   = pc_mem[rd_top];
  assign top_mask = mask_mem[rd_top];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (push_two) begin
      sp <= sp + SPW'(2);
    end else if (pop && !empty) begin
      sp <= sp - SPW'(1);
    end
  end

  // The record array is not reset; sp alone says which records are live
  always_ff @(posedge clk) begin
    if (push_two) begin
      pc_mem[wr_lo]   <= lo_pc;
      mask_mem[wr_lo] <= lo_mask;
      pc_mem[wr_hi]   <= hi_pc;
      mask_mem[wr_hi] <= hi_mask;
    end
  end

  // R4
  push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_two |=> sp == $past(sp) + SPW'(2));

  // R6
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push_two) |=> sp == $past(sp) - SPW'(1));

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sp) <= DEPTH);

endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack
  import simt_div_pkg::*;
#(
  parameter int          LANES    = 32,
  parameter int          PCW      = 32,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] RESET_PC = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PCW-1:0]   br_target,
  input  logic [PCW-1:0]   br_fallthru,
  input  logic [PCW-1:0]   br_join_pc,
  input  logic             path_end,
  output logic [PCW-1:0]   path_pc,
  output logic [LANES-1:0] act_mask,
  output logic             stack_ovf
);

  logic [LANES-1:0] taken_act, nt_act;
  br_kind_e         kind;
  logic [PCW-1:0]   top_pc;
  logic [LANES-1:0] top_mask;
  logic             stk_empty, stk_room2;

  // Named events for the checks below
  logic div_ok, div_ovf, pop_fire, uni_fire;

  simt_branch_eval #(.LANES(LANES)) u_eval (
    .valid     (br_valid),
    .active    (act_mask),
    .taken     (br_taken),
    .taken_act (taken_act),
    .nt_act    (nt_act),
    .kind      (kind)
  );

  assign div_ok   = (kind == BK_SPLIT) &&  stk_room2;
  assign div_ovf  = (kind == BK_SPLIT) && !stk_room2;
  assign uni_fire = (kind == BK_TAKEN) || (kind == BK_NOTTAKEN);
  assign pop_fire = path_end && !br_valid && !stk_empty;

  simt_recon_lifo #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u_lifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_two (div_ok),
    .lo_pc    (br_join_pc),
    .lo_mask  (act_mask),
    .hi_pc    (br_target),
    .hi_mask  (taken_act),
    .pop      (pop_fire),
    .top_pc   (top_pc),
    .top_mask (top_mask),
    .empty    (stk_empty),
    .room_two (stk_room2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      path_pc   <= PCW'(RESET_PC);
      act_mask  <= '1;
      stack_ovf <= 1'b0;
    end else if (br_valid) begin
      unique case (kind)
        BK_TAKEN:    path_pc <= br_target;
        BK_NOTTAKEN: path_pc <= br_fallthru;
        BK_SPLIT: begin
          if (stk_room2) begin
            path_pc  <= br_fallthru;
            act_mask <= nt_act;
          end else begin
            stack_ovf <= 1'b1;
          end
        end
        default: ;
      endcase
    end else if (pop_fire) begin
      path_pc  <= top_pc;
      act_mask <= top_mask;
    end
  end

  // R2
  uniform_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uni_fire |=> act_mask == $past(act_mask));

  // R5
  subset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (act_mask & ~$past(act_mask)) == '0);

  // R7
  empty_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_empty |-> act_mask == '1);

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_ovf |=> (stack_ovf && $stable(act_mask) && $stable(path_pc)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);

  // R10
  branch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && path_end && uni_fire) |=> act_mask == $past(act_mask));

endmodule

// File: tb/simt_div_stack_test.sv
module simt_div_stack_test;

  localparam int L = 32;
  localparam int P = 32;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         br_valid, path_end;
  logic [L-1:0] br_taken;
  logic [P-1:0] br_target, br_fallthru, br_join_pc;
  logic [P-1:0] path_pc;
  logic [L-1:0] act_mask;
  logic         stack_ovf;

  always #2.5 clk = ~clk;

  simt_div_stack uut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .br_fallthru(br_fallthru), .br_join_pc(br_join_pc),
    .path_end(path_end), .path_pc(path_pc), .act_mask(act_mask),
    .stack_ovf(stack_ovf)
  );

  typedef struct {
    logic [P-1:0] pc;
    logic [L-1:0] mask;
    logic         ovf;
    string        tag;
  } exp_t;

  exp_t         scb[$];
  int           n_cmp = 0, n_bad = 0;
  bit           done = 0;

  // Reference state, kept independently of the design
  logic [P-1:0] m_pc;
  logic [L-1:0] m_mask;
  logic         m_ovf;
  logic [P-1:0] s_pc[$];
  logic [L-1:0] s_mask[$];

  function automatic void compare(exp_t e);
    n_cmp++;
    if (path_pc !== e.pc || act_mask !== e.mask || stack_ovf !== e.ovf) begin
      n_bad++;
      $display("FAIL %s: got pc=%h mask=%h ovf=%b, expected pc=%h mask=%h ovf=%b",
               e.tag, path_pc, act_mask, stack_ovf, e.pc, e.mask, e.ovf);
    end
  endfunction

  function automatic void model_reset();
    m_pc = 32'h100; m_mask = '1; m_ovf = 1'b0;
    s_pc.delete(); s_mask.delete();
  endfunction

  task automatic expect_now(string tag);
    exp_t e;
    e.pc = m_pc; e.mask = m_mask; e.ovf = m_ovf; e.tag = tag;
    scb.push_back(e);
  endtask

  // Driver: branch, optionally with a simultaneous path-end pulse
  task automatic branch(input logic [L-1:0] tk, input logic [P-1:0] tgt,
                        input logic [P-1:0] ft, input logic [P-1:0] jn,
                        input bit also_end, input string tag);
    logic [L-1:0] hit;
    @(negedge clk);
    br_valid = 1'b1; br_taken = tk; br_target = tgt;
    br_fallthru = ft; br_join_pc = jn; path_end = also_end;
    hit = tk & m_mask;
    if (hit == '0) m_pc = ft;
    else if (hit == m_mask) m_pc = tgt;
    else if (s_pc.size() + 2 <= D) begin
      s_pc.push_back(jn);  s_mask.push_back(m_mask);
      s_pc.push_back(tgt); s_mask.push_back(hit);
      m_pc = ft; m_mask = m_mask ^ hit;
    end else m_ovf = 1'b1;
    expect_now(tag);
  endtask

  task automatic end_path(input string tag);
    @(negedge clk);
    br_valid = 1'b0; path_end = 1'b1;
    if (s_pc.size() > 0) begin
      m_pc = s_pc.pop_back(); m_mask = s_mask.pop_back();
    end
    expect_now(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    br_valid = 1'b0; path_end = 1'b0; br_taken = '0;
  endtask

  // Monitor: compare one result after each active edge
  always @(posedge clk) begin
    #1;
    if (scb.size() > 0) compare(scb.pop_front());
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; br_valid = 1'b0; path_end = 1'b0; br_taken = '0;
    br_target = '0; br_fallthru = '0; br_join_pc = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #0.5;
    begin
      exp_t e;
      e.pc = m_pc; e.mask = m_mask; e.ovf = m_ovf; e.tag = "R1 reset";
      compare(e);
    end
  endtask

  initial begin
    rst_n = 1'b0; br_valid = 1'b0; path_end = 1'b0; br_taken = '0;
    br_target = '0; br_fallthru = '0; br_join_pc = '0;
    model_reset();
    do_reset();

    end_path("R7 empty pop");
    branch(32'hFFFF_FFFF, 32'h200, 32'h1F0, 32'h0, 0, "R2 all taken");
    branch(32'h0000_0000, 32'h2F0, 32'h204, 32'h0, 0, "R3 none taken");
    branch(32'h0000_FFFF, 32'h300, 32'h240, 32'h280, 0, "R4 split");
    branch(32'h00FF_00FF, 32'h400, 32'h340, 32'h380, 0, "R5 nested split gated");
    branch(32'h0000_FF00, 32'h4F0, 32'h344, 32'h0, 0, "R5 inactive taken ignored");
    branch(32'hFF00_FFFF, 32'h360, 32'h350, 32'h0, 0, "R5 R2 subset all taken");
    branch(32'hFFFF_FFFF, 32'h370, 32'h36C, 32'h0, 1, "R10 branch beats path end");
    end_path("R6 pop taken inner");
    end_path("R6 pop join inner");
    end_path("R6 pop taken outer");
    end_path("R6 pop join outer");
    end_path("R7 pop past empty");

    branch(32'h5555_5555, 32'h500, 32'h504, 32'h5F0, 0, "R4 fill 1");
    branch(32'h3333_3333, 32'h510, 32'h514, 32'h5E0, 0, "R4 fill 2");
    branch(32'h0F0F_0F0F, 32'h520, 32'h524, 32'h5D0, 0, "R4 fill 3");
    branch(32'h00FF_00FF, 32'h530, 32'h534, 32'h5C0, 0, "R4 fill 4");
    branch(32'h0000_FFFF, 32'h540, 32'h544, 32'h5B0, 0, "R8 overflow split");
    branch(32'hFFFF_FFFF, 32'h550, 32'h548, 32'h0, 0, "R9 sticky after branch");
    for (int i = 0; i < 8; i++) end_path("R6 R9 drain");
    end_path("R7 R9 empty after drain");
    idle();
    idle();

    do_reset();
    idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule